// File: doc/BRIEF.md
# Register Bank Stack Sequencer

This block holds a bank of eight general-purpose registers together with a stack pointer, and moves register contents to and from a stack memory built into the block. Software-side logic issues one of four commands. Two of them move a single register: a push moves a register onto the stack, and a pop moves the top of the stack into a register. The other two move the whole bank: a bulk save writes every register onto the stack in a fixed order, and a bulk restore reads them back in the opposite order. The stack grows downward. The pointer is a byte address that moves by the register width in bytes, and the memory is addressed in words.

A command is accepted in a cycle where the sequencer is idle. Busy then stays high while the memory steps run, and a one-cycle done pulse marks the cycle in which every result is visible. The same port that is used to preload registers before a save also reads them back after a restore. Register index 4 is the stack pointer itself, so writing or reading index 4 accesses the pointer.

Top module: `regstack_seq`

## Requirements
- R1: A push (cmd_op 0) first lowers the pointer by DATA_W/8 bytes, modulo the stack size in bytes, and then stores the selected register at the new pointer. Pushing index 4 stores the pointer value from before the push. The pointer can be observed as stack_ptr or as register 4.
- R2: A pop (cmd_op 1) reads the word at the current pointer, raises the pointer by DATA_W/8, and loads the word into the selected register. Popping into index 4 replaces the pointer with the popped word.
- R3: After two pushes, two pops into swapped destinations exchange the two values, because the last word in is the first word out.
- R4: A bulk save (cmd_op 2) pushes the registers by index 0 to 7. The indices are 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI and 7 DI. Register 7 therefore ends on top, and the pointer ends 8*DATA_W/8 bytes lower.
- R5: The word that a bulk save stores for index 4 is the pointer value from before the save began.
- R6: A bulk restore (cmd_op 3) pops into indices 7 down to 0. The word in the index-4 slot is discarded, and the pointer still advances, so that it ends 8*DATA_W/8 bytes higher than where the restore started.
- R7: Busy rises in the cycle after acceptance. It stays high for 1 cycle after a push, 2 after a pop, 8 after a bulk save and 9 after a bulk restore. Done then pulses for exactly one cycle, with busy low.
- R8: A command presented while busy is ignored and is not queued.
- R9: A register write presented while busy is ignored. A register write presented in the same cycle that a command is accepted takes effect before the command's first step.
- R10: After reset, all registers and the pointer read zero, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 bulk save, 3 bulk restore |
| cmd_reg | input | 3 | Register index for push and pop |
| reg_we | input | 1 | Register write strobe, taken only when idle |
| reg_widx | input | 3 | Register write index (4 = pointer) |
| reg_wdata | input | DATA_W | Register write data |
| reg_ridx | input | 3 | Register read index (4 = pointer) |
| reg_rdata | output | DATA_W | Combinational register read data |
| stack_ptr | output | PTR_W | Current stack pointer (byte address) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The collision that matters is a register write that lands in the same cycle as a command acceptance. If the write were applied after the command's first step, a push of that register would store the stale value. The bench presents a write to AX and a push of AX on the same clock edge, then pops the result into another register and expects the new value. It also drives a write and a second command while a bulk save is running, and expects that neither one changes the registers, the pointer or the busy window.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;
  localparam logic [IDX_W-1:0] SP_SLOT = 3'd4;

  // bit 0 = pop direction, bit 1 = whole bank
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_SAVEALL = 2'd2,
    OP_LOADALL = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/regstack_ram.sv
module regstack_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/regstack_rf.sv
module regstack_rf
  import regstack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                            regs[g] <= '0;
      else if (we && widx == IDX_W'(g))      regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];
endmodule

// File: rtl/regstack_ctrl.sv
module regstack_ctrl
  import regstack_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_WORDS = 64,
  localparam int BYTES      = DATA_W / 8,
  localparam int BYTE_SH    = $clog2(BYTES),
  localparam int AW         = $clog2(STACK_WORDS),
  localparam int PTR_W      = AW + BYTE_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [IDX_W-1:0]  rf_ridx,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [PTR_W-1:0]  sp,
  output logic              busy,
  output logic              done
);
  // pointer arithmetic
  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(BYTES);
  endfunction
  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(BYTES);
  endfunction
  function automatic logic [AW-1:0] word_of(input logic [PTR_W-1:0] p);
    return p[PTR_W-1:BYTE_SH];
  endfunction
  // register touched at a given step: bank order up for save, down for restore
  function automatic logic [IDX_W-1:0] step_reg(input logic [1:0] op,
                                                input logic [2:0] step,
                                                input logic [IDX_W-1:0] single);
    if (!op[1])     return single;
    else if (op[0]) return ~step;
    else            return step;
  endfunction

  seq_state_e        state_q;
  logic [1:0]        op_q;
  logic [IDX_W-1:0]  reg_q;
  logic [2:0]        step_q;
  logic [PTR_W-1:0]  sp_q;
  logic [DATA_W-1:0] snap_q;
  logic              wb_v_q;
  logic [IDX_W-1:0]  wb_idx_q;
  logic              done_q;

  // named internal events
  logic             accept, host_ok, step_fire, push_fire, pop_fire, wb_fire, seq_last;
  logic             is_all, is_pop;
  logic [IDX_W-1:0] cur_idx;
  logic [DATA_W-1:0] push_word;

  assign is_all    = op_q[1];
  assign is_pop    = op_q[0];
  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign host_ok   = (state_q == ST_IDLE) && host_we;
  assign step_fire = (state_q == ST_STEP);
  assign push_fire = step_fire && !is_pop;
  assign pop_fire  = step_fire && is_pop;
  assign wb_fire   = wb_v_q;
  assign seq_last  = !is_all || (step_q == 3'd7);
  assign cur_idx   = step_reg(op_q, step_q, reg_q);

  always_comb begin
    push_word = rf_rdata;
    if (cur_idx == SP_SLOT) push_word = is_all ? snap_q : DATA_W'(sp_q);
  end

  assign rf_ridx   = cur_idx;
  assign ram_en    = step_fire;
  assign ram_we    = push_fire;
  assign ram_addr  = push_fire ? word_of(ptr_down(sp_q)) : word_of(sp_q);
  assign ram_wdata = push_word;

  assign rf_we    = wb_fire || host_ok;
  assign rf_widx  = wb_fire ? wb_idx_q : host_idx;
  assign rf_wdata = wb_fire ? ram_rdata : host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (host_ok && host_idx == SP_SLOT) begin
      sp_q <= host_wdata[PTR_W-1:0];
    end else if (push_fire) begin
      sp_q <= ptr_down(sp_q);
    end else if (pop_fire) begin
      sp_q <= ptr_up(sp_q);
    end else if (wb_fire && wb_idx_q == SP_SLOT) begin
      sp_q <= ram_rdata[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= '0;
    else if (step_fire && step_q == 3'd0) snap_q <= DATA_W'(sp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_v_q   <= 1'b0;
      wb_idx_q <= '0;
    end else begin
      wb_v_q   <= pop_fire && !(is_all && cur_idx == SP_SLOT);
      wb_idx_q <= cur_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 2'd0;
      reg_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= cmd_op;
          reg_q   <= cmd_idx;
          step_q  <= '0;
          state_q <= ST_STEP;
        end
        ST_STEP: begin
          step_q <= step_q + 3'd1;
          if (seq_last) begin
            state_q <= is_pop ? ST_DRAIN : ST_IDLE;
            done_q  <= !is_pop;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sp   = sp_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R1: each push step lowers the pointer by one word
  p_push_lowers_sp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_q == PTR_W'($past(sp_q) - PTR_W'(BYTES)));
  // R2: each pop step raises the pointer by one word
  p_pop_raises_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp_q == PTR_W'($past(sp_q) + PTR_W'(BYTES)));
  // R6: the pointer slot read during a bulk restore is never written back
  p_restore_skips_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && is_all && cur_idx == SP_SLOT) |=> !wb_fire);
  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: done follows a busy cycle and comes with busy low
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy)));
  // R8: a command while busy leaves the captured command untouched
  p_busy_ignores_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(op_q) && $stable(reg_q)));
  // R9: memory writes only happen inside a sequence
  p_ram_write_in_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
  import regstack_pkg::*;
#(
  parameter int  DATA_W      = 16,
  parameter int  STACK_WORDS = 64,
  localparam int PTR_W       = $clog2(STACK_WORDS) + $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_reg,
  input  logic              reg_we,
  input  logic [2:0]        reg_widx,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [2:0]        reg_ridx,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PTR_W-1:0]  stack_ptr,
  output logic              busy,
  output logic              done
);
  localparam int AW = $clog2(STACK_WORDS);

  logic              rf_we;
  logic [IDX_W-1:0]  rf_widx, rf_ridx;
  logic [DATA_W-1:0] rf_wdata, rf_host_rd, rf_seq_rd;
  logic              ram_en, ram_we;
  logic [AW-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic [PTR_W-1:0]  sp;

  regstack_rf #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ridx_a(reg_ridx), .rdata_a(rf_host_rd),
    .ridx_b(rf_ridx), .rdata_b(rf_seq_rd)
  );

  regstack_ram #(.DATA_W(DATA_W), .DEPTH(STACK_WORDS)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  regstack_ctrl #(.DATA_W(DATA_W), .STACK_WORDS(STACK_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_reg),
    .host_we(reg_we), .host_idx(reg_widx), .host_wdata(reg_wdata),
    .rf_rdata(rf_seq_rd), .ram_rdata(ram_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .rf_ridx(rf_ridx),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .sp(sp), .busy(busy), .done(done)
  );

  assign reg_rdata = (reg_ridx == SP_SLOT) ? DATA_W'(sp) : rf_host_rd;
  assign stack_ptr = sp;
endmodule

// File: tb/regstack_seq_tb.sv
module regstack_seq_tb;
  localparam int DATA_W = 16;
  localparam int STACK_WORDS = 64;
  localparam int PTR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_reg = 3'd0;
  logic reg_we = 1'b0;
  logic [2:0] reg_widx = 3'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [2:0] reg_ridx = 3'd0;
  logic [DATA_W-1:0] reg_rdata;
  logic [PTR_W-1:0] stack_ptr;
  logic busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  regstack_seq #(.DATA_W(DATA_W), .STACK_WORDS(STACK_WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .reg_we(reg_we), .reg_widx(reg_widx),
    .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
    .stack_ptr(stack_ptr), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] idx, input logic [DATA_W-1:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_widx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [DATA_W-1:0] val);
    reg_ridx = idx;
    #1;
    val = reg_rdata;
  endtask

  // waits from the negedge after acceptance until done; returns busy cycles
  task automatic wait_done(output int bcnt);
    int guard = 0;
    bcnt = 0;
    while (!done && guard < 100) begin
      if (busy) bcnt++;
      guard++;
      @(negedge clk);
    end
    @(negedge clk);
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run(input logic [1:0] op, input logic [2:0] idx, output int bcnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(bcnt);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), v);
      chk("R10 reset reg", v, 0);
    end
    chk("R10 reset busy", {31'd0, busy}, 0);
    chk("R10 reset done", {31'd0, done}, 0);
  endtask

  task automatic t_swap();
    int b;
    logic [DATA_W-1:0] v;
    host_wr(3'd4, 16'h0040);
    host_wr(3'd0, 16'h1111);
    host_wr(3'd3, 16'h2222);
    run(2'd0, 3'd0, b);
    chk("R7 push busy", b, 1);
    chk("R1 push sp", stack_ptr, 7'h3E);
    run(2'd0, 3'd3, b);
    chk("R1 second push sp", stack_ptr, 7'h3C);
    run(2'd1, 3'd0, b);
    chk("R7 pop busy", b, 2);
    rd(3'd0, v);
    chk("R2 pop value", v, 16'h2222);
    chk("R2 pop sp", stack_ptr, 7'h3E);
    run(2'd1, 3'd3, b);
    rd(3'd3, v);
    chk("R3 swapped BX", v, 16'h1111);
    rd(3'd0, v);
    chk("R3 swapped AX", v, 16'h2222);
    chk("R3 sp back", stack_ptr, 7'h40);
  endtask

  task automatic t_sp_slot();
    int b;
    logic [DATA_W-1:0] v;
    host_wr(3'd4, 16'h0040);
    run(2'd0, 3'd4, b);
    run(2'd1, 3'd1, b);
    rd(3'd1, v);
    chk("R1 push of SP stores pre-push value", v, 16'h0040);
    host_wr(3'd2, 16'h0030);
    run(2'd0, 3'd2, b);
    run(2'd1, 3'd4, b);
    rd(3'd4, v);
    chk("R2 pop into SP", v, 16'h0030);
  endtask

  task automatic t_wrap();
    int b;
    logic [DATA_W-1:0] v;
    host_wr(3'd4, 16'h0000);
    host_wr(3'd0, 16'h5A5A);
    run(2'd0, 3'd0, b);
    chk("R1 wrap sp", stack_ptr, 7'h7E);
    run(2'd1, 3'd1, b);
    rd(3'd1, v);
    chk("R2 wrap pop value", v, 16'h5A5A);
    chk("R2 wrap sp", stack_ptr, 7'h00);
  endtask

  task automatic t_save_order();
    int b;
    logic [DATA_W-1:0] v;
    for (int k = 0; k < 8; k++) if (k != 4) host_wr(3'(k), 16'hA000 + 16'(k));
    host_wr(3'd4, 16'h0040);
    run(2'd2, 3'd0, b);
    chk("R7 save busy", b, 8);
    chk("R4 save sp", stack_ptr, 7'h30);
    for (int k = 7; k >= 0; k--) begin
      run(2'd1, 3'd1, b);
      rd(3'd1, v);
      if (k == 4) chk("R5 saved SP slot", v, 16'h0040);
      else        chk("R4 save order", v, 16'hA000 + 16'(k));
    end
    chk("R4 sp after pops", stack_ptr, 7'h40);
  endtask

  task automatic t_restore();
    int b;
    logic [DATA_W-1:0] v;
    for (int k = 0; k < 8; k++) if (k != 4) host_wr(3'(k), 16'hB000 + 16'(k));
    host_wr(3'd4, 16'h0040);
    for (int k = 0; k < 8; k++) begin
      if (k == 4) begin
        host_wr(3'd1, 16'h0777);
        run(2'd0, 3'd1, b);
      end else begin
        run(2'd0, 3'(k), b);
      end
    end
    for (int k = 0; k < 8; k++) if (k != 4) host_wr(3'(k), 16'h0000);
    run(2'd3, 3'd0, b);
    chk("R7 restore busy", b, 9);
    for (int k = 0; k < 8; k++) if (k != 4) begin
      rd(3'(k), v);
      chk("R6 restored reg", v, 16'hB000 + 16'(k));
    end
    chk("R6 sp after restore", stack_ptr, 7'h40);
  endtask

  task automatic t_busy_ignore();
    int b;
    logic [DATA_W-1:0] v;
    host_wr(3'd4, 16'h0040);
    host_wr(3'd0, 16'h0101);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_reg = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_reg = 3'd2;
    reg_we = 1'b1; reg_widx = 3'd0; reg_wdata = 16'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0; reg_we = 1'b0;
    wait_done(b);
    chk("R8 busy window unchanged", b, 7);
    repeat (3) @(negedge clk);
    chk("R8 no queued command", {31'd0, busy}, 0);
    chk("R8 sp from save only", stack_ptr, 7'h30);
    rd(3'd0, v);
    chk("R9 write while busy ignored", v, 16'h0101);
  endtask

  task automatic t_same_cycle();
    int b;
    logic [DATA_W-1:0] v;
    host_wr(3'd4, 16'h0040);
    host_wr(3'd0, 16'h0000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_reg = 3'd0;
    reg_we = 1'b1; reg_widx = 3'd0; reg_wdata = 16'h1234;
    @(negedge clk);
    cmd_valid = 1'b0; reg_we = 1'b0;
    wait_done(b);
    run(2'd1, 3'd2, b);
    rd(3'd2, v);
    chk("R9 same-cycle write pushed", v, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swap();
    t_sp_slot();
    t_wrap();
    t_save_order();
    t_restore();
    t_busy_ignore();
    t_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule